// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a 16-bit up-counting watchdog. It raises an early-warning interrupt and requests a system reset when its count reaches programmable thresholds. Software cannot change its behaviour with a plain register write. Every command travels through an 8-bit key register in two steps: an attention key arms the interface, and the key that follows picks the action. The actions are restarting the count, stopping or starting the timer, granting one register write, or locking the block until the next reset.

A small 32-bit register port carries writes with a single strobe and returns read data combinationally for the address on the bus. The port has no back-pressure, so every write is taken in the cycle its strobe is high. The port decodes these byte addresses:

| Address | Register |
|---|---|
| 0x00 | control |
| 0x04 | control set-alias |
| 0x08 | control clear-alias |
| 0x10 | status |
| 0x14 | status set-alias |
| 0x18 | status clear-alias |
| 0x20 | thresholds |
| 0x30 | key |

A new threshold value is staged at once. It reaches the comparators only after a fixed delay, and a busy flag covers that delay. A debug-halt input can freeze the count when the control register allows it.

Top module: `kwdog_top`

## Requirements
- R1: After reset, control, status and key read 0, the threshold register reads 0xFFFF_FFF0, the timer is stopped with count 0, and warn_irq and reset_req are low.
- R2: A key write of 0xA5 while the interface is idle sets status bit 0 (armed). The next key write of any value clears it.
- R3: A command key 0xF1 after attention sets status bit 1 (write granted). The next write to any non-key register address listed in the brief uses up the grant, whether or not the write takes effect. Such a write without a grant changes nothing.
- R4: A key other than 0xA5 while idle does nothing. A key after attention other than 0xCC, 0xDD, 0xEE, 0xF1 and 0xFF returns the interface to idle with no action.
- R5: Command 0xFF locks the block until reset. It clears any grant, makes 0xF1, 0xDD and 0xEE ignored, and leaves 0xCC (restart) working.
- R6: Command 0xEE starts the timer, 0xDD stops it and 0xCC sets the count to 0. A running, unfrozen timer advances by one each cycle.
- R7: Status bit 3 reads 1 exactly while the count is at or above the active reset threshold (bits 31:16). reset_req pulses for one cycle when an advance brings the count equal to that threshold.
- R8: Status bit 2 (warning flag) sets when an advance brings the count equal to the active early-warning threshold (bits 15:0). warn_irq equals that flag ANDed with control bit 0.
- R9: A granted write to the status register sets bit 2 to data bit 2. Writing 0 clears the flag and writing 1 forces it. The set-alias and clear-alias set or clear the flag where data bit 2 is 1.
- R10: The control set-alias (0x04) ORs data bits 1:0 into control, and the clear-alias (0x08) clears the bits given.
- R11: An accepted threshold write is readable at once. Status bit 4 (busy) is then 1 for exactly 3 cycles, and the comparators switch to the new value at the end of that interval. A threshold write that arrives while busy is 1 is ignored.
- R12: With control bit 1 set, the count holds while dbg_halt is high. With control bit 1 clear, dbg_halt has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| dbg_halt | input | 1 | Debug halt from the core |
| warn_irq | output | 1 | Early-warning interrupt |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach from the ports is a second threshold write that lands in the last busy cycle. Because each write needs a fresh grant, and a grant takes two key writes, the bench grants, writes the thresholds, re-grants over the next two cycles and writes again on the third. It then checks that the first value alone took effect, that busy dropped, and that the ignored write still used up the grant. Full sweeps of all 256 key values test both the idle and armed paths after a fresh reset each time. Counting tests check the threshold crossings and the debug-halt freeze cycle by cycle.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;
  localparam int KEY_W = 8;
  localparam int ADDR_W = 6;

  localparam logic [KEY_W-1:0] KEY_ATTN    = 8'hA5;
  localparam logic [KEY_W-1:0] KEY_RESTART = 8'hCC;
  localparam logic [KEY_W-1:0] KEY_STOP    = 8'hDD;
  localparam logic [KEY_W-1:0] KEY_START   = 8'hEE;
  localparam logic [KEY_W-1:0] KEY_GRANT   = 8'hF1;
  localparam logic [KEY_W-1:0] KEY_LOCK    = 8'hFF;

  localparam logic [ADDR_W-1:0] A_CTRL     = 6'h00;
  localparam logic [ADDR_W-1:0] A_CTRL_SET = 6'h04;
  localparam logic [ADDR_W-1:0] A_CTRL_CLR = 6'h08;
  localparam logic [ADDR_W-1:0] A_STAT     = 6'h10;
  localparam logic [ADDR_W-1:0] A_STAT_SET = 6'h14;
  localparam logic [ADDR_W-1:0] A_STAT_CLR = 6'h18;
  localparam logic [ADDR_W-1:0] A_THR      = 6'h20;
  localparam logic [ADDR_W-1:0] A_KEY      = 6'h30;

  typedef enum logic {KS_IDLE, KS_ARMED} kstate_t;

  typedef struct packed {
    logic restart;
    logic stop;
    logic start;
    logic grant;
    logic lock;
  } kwdog_cmd_t;
endpackage

// File: rtl/kwdog_keyseq.sv
module kwdog_keyseq
  import kwdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_val,
  input  logic             reg_try,
  output logic             armed,
  output logic             priv,
  output logic             locked,
  output kwdog_cmd_t       cmd
);
  kstate_t st_q;
  logic    hit;

  assign hit   = key_we && (st_q == KS_ARMED);
  assign armed = (st_q == KS_ARMED);

  always_comb begin
    cmd         = '0;
    cmd.restart = hit && (key_val == KEY_RESTART);
    cmd.stop    = hit && (key_val == KEY_STOP)  && !locked;
    cmd.start   = hit && (key_val == KEY_START) && !locked;
    cmd.grant   = hit && (key_val == KEY_GRANT) && !locked;
    cmd.lock    = hit && (key_val == KEY_LOCK)  && !locked;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= KS_IDLE;
      priv   <= 1'b0;
      locked <= 1'b0;
    end else begin
      if (key_we) begin
        if (st_q == KS_IDLE && key_val == KEY_ATTN) st_q <= KS_ARMED;
        else                                        st_q <= KS_IDLE;
      end
      if (cmd.lock)       priv <= 1'b0;
      else if (cmd.grant) priv <= 1'b1;
      else if (reg_try)   priv <= 1'b0;
      if (cmd.lock) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/kwdog_core.sv
module kwdog_core
  import kwdog_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  kwdog_cmd_t       cmd,
  input  logic             freeze,
  input  logic [CNT_W-1:0] ewth,
  input  logic [CNT_W-1:0] rth,
  output logic [CNT_W-1:0] cnt,
  output logic             ewi_hit,
  output logic             rth_flag,
  output logic             reset_req
);
  localparam int NCMP = 2;

  logic             running;
  logic             advance;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] thr_v [NCMP];
  logic [NCMP-1:0]  match;

  assign thr_v[0] = ewth;
  assign thr_v[1] = rth;
  assign cnt_nxt  = cnt + 1'b1;
  assign advance  = running && !freeze && !cmd.restart;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    assign match[g] = (cnt_nxt == thr_v[g]);
  end

  assign ewi_hit  = advance && match[0];
  assign rth_flag = (cnt >= rth);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      running   <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      if (cmd.restart)  cnt <= '0;
      else if (advance) cnt <= cnt_nxt;
      if (cmd.stop)       running <= 1'b0;
      else if (cmd.start) running <= 1'b1;
      reset_req <= advance && match[1];
    end
  end
endmodule

// File: rtl/kwdog_regs.sv
module kwdog_regs
  import kwdog_pkg::*;
#(
  parameter int               CNT_W     = 16,
  parameter int               UPD_DLY   = 3,
  parameter logic [CNT_W-1:0] EWTH_INIT = 16'hFFF0,
  parameter logic [CNT_W-1:0] RTH_INIT  = 16'hFFFF
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [2*CNT_W-1:0] wdata,
  input  logic               ewi_hit,
  input  logic               rth_flag,
  input  logic               armed,
  input  logic               priv,
  output logic [1:0]         ctrl,
  output logic               ewi_flag,
  output logic               busy,
  output logic               thr_acc,
  output logic [CNT_W-1:0]   ewth_act,
  output logic [CNT_W-1:0]   rth_act,
  output logic [2*CNT_W-1:0] rdata
);
  localparam int DATA_W = 2 * CNT_W;
  localparam int DLY_W  = $clog2(UPD_DLY + 1);

  logic [CNT_W-1:0] ewth_stg, rth_stg;
  logic [DLY_W-1:0] dly;

  assign busy    = (dly != '0);
  assign thr_acc = wr_en && (addr == A_THR) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ewth_stg <= EWTH_INIT;
      rth_stg  <= RTH_INIT;
      ewth_act <= EWTH_INIT;
      rth_act  <= RTH_INIT;
      dly      <= '0;
    end else if (thr_acc) begin
      ewth_stg <= wdata[CNT_W-1:0];
      rth_stg  <= wdata[DATA_W-1:CNT_W];
      dly      <= DLY_W'(UPD_DLY);
    end else if (busy) begin
      dly <= dly - 1'b1;
      if (dly == DLY_W'(1)) begin
        ewth_act <= ewth_stg;
        rth_act  <= rth_stg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= 2'b00;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:     ctrl <= wdata[1:0];
        A_CTRL_SET: ctrl <= ctrl | wdata[1:0];
        A_CTRL_CLR: ctrl <= ctrl & ~wdata[1:0];
        default:    ctrl <= ctrl;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ewi_flag <= 1'b0;
    end else if (ewi_hit) begin
      ewi_flag <= 1'b1;
    end else if (wr_en) begin
      case (addr)
        A_STAT:     ewi_flag <= wdata[2];
        A_STAT_SET: ewi_flag <= ewi_flag | wdata[2];
        A_STAT_CLR: ewi_flag <= ewi_flag & ~wdata[2];
        default:    ewi_flag <= ewi_flag;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[1:0] = ctrl;
      A_STAT:  rdata[4:0] = {busy, rth_flag, ewi_flag, priv, armed};
      A_THR:   rdata      = {rth_stg, ewth_stg};
      default: rdata      = '0;
    endcase
  end
endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
  import kwdog_pkg::*;
#(
  parameter int               CNT_W     = 16,
  parameter int               UPD_DLY   = 3,
  parameter logic [CNT_W-1:0] EWTH_INIT = 16'hFFF0,
  parameter logic [CNT_W-1:0] RTH_INIT  = 16'hFFFF
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [2*CNT_W-1:0]  reg_wdata,
  output logic [2*CNT_W-1:0]  reg_rdata,
  input  logic                dbg_halt,
  output logic                warn_irq,
  output logic                reset_req
);
  localparam int DATA_W = 2 * CNT_W;

  logic             key_we, reg_try, wr_en, mapped;
  logic             armed, priv, locked;
  logic             ewi_hit, rth_flag, ewi_flag, busy, thr_acc, halt_frz;
  logic [1:0]       ctrl_q;
  logic [CNT_W-1:0] cnt, ewth_act, rth_act;
  kwdog_cmd_t       cmd;

  always_comb begin
    case (reg_addr)
      A_CTRL, A_CTRL_SET, A_CTRL_CLR,
      A_STAT, A_STAT_SET, A_STAT_CLR,
      A_THR:   mapped = 1'b1;
      default: mapped = 1'b0;
    endcase
  end

  assign key_we   = reg_we && (reg_addr == A_KEY);
  assign reg_try  = reg_we && mapped;
  assign wr_en    = reg_try && priv;
  assign halt_frz = ctrl_q[1] && dbg_halt;
  assign warn_irq = ewi_flag && ctrl_q[0];

  kwdog_keyseq u_keys (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_val(reg_wdata[KEY_W-1:0]),
    .reg_try(reg_try), .armed(armed), .priv(priv), .locked(locked), .cmd(cmd)
  );

  kwdog_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .freeze(halt_frz),
    .ewth(ewth_act), .rth(rth_act), .cnt(cnt), .ewi_hit(ewi_hit),
    .rth_flag(rth_flag), .reset_req(reset_req)
  );

  kwdog_regs #(.CNT_W(CNT_W), .UPD_DLY(UPD_DLY), .EWTH_INIT(EWTH_INIT),
               .RTH_INIT(RTH_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(reg_addr),
    .wdata(reg_wdata[DATA_W-1:0]), .ewi_hit(ewi_hit), .rth_flag(rth_flag),
    .armed(armed), .priv(priv), .ctrl(ctrl_q), .ewi_flag(ewi_flag),
    .busy(busy), .thr_acc(thr_acc), .ewth_act(ewth_act), .rth_act(rth_act),
    .rdata(reg_rdata)
  );
endmodule

// File: rtl/kwdog_chk.sv
module kwdog_chk #(
  parameter int CNT_W = 16
)(
  input logic             clk,
  input logic             rst_n,
  input logic             key_we,
  input logic [7:0]       key_val,
  input logic             reg_try,
  input logic             armed,
  input logic             priv,
  input logic             locked,
  input logic             thr_acc,
  input logic             busy,
  input logic             halt_frz,
  input logic [CNT_W-1:0] cnt,
  input logic             reset_req
);
  AST_ARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    armed && key_we |=> !armed); // R2
  AST_PRIV_USED: assert property (@(posedge clk) disable iff (!rst_n)
    priv && reg_try |=> !priv); // R3
  AST_IDLE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && key_we && key_val != 8'hA5 |=> !armed); // R4
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R5
  AST_LOCK_NOPRIV: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !priv); // R5
  AST_RST_ONECYC: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req); // R7
  AST_BUSY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    thr_acc |=> busy); // R11
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    halt_frz && !key_we |=> cnt == $past(cnt)); // R12
endmodule

bind kwdog_top kwdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_val(reg_wdata[7:0]),
  .reg_try(reg_try), .armed(armed), .priv(priv), .locked(locked),
  .thr_acc(thr_acc), .busy(busy), .halt_frz(halt_frz), .cnt(cnt),
  .reset_req(reset_req)
);

// File: tb/sim_kwdog_top.sv
`timescale 1ns/100ps
module sim_kwdog_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dbg_halt = 1'b0;
  logic        warn_irq, reset_req;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  kwdog_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_halt(dbg_halt),
    .warn_irq(warn_irq), .reset_req(reset_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic key2(input logic [7:0] k);
    wr(6'h30, 32'hA5);
    wr(6'h30, {24'h0, k});
  endtask

  task automatic gwr(input logic [5:0] a, input logic [31:0] d);
    key2(8'hF1);
    wr(a, d);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_we = 1'b0; dbg_halt = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1 reset state
    rd(6'h00, v); chk("R1 ctrl", v, 0);
    rd(6'h10, v); chk("R1 status", v, 0);
    rd(6'h20, v); chk("R1 thr", v, 32'hFFFF_FFF0);
    rd(6'h30, v); chk("R1 key", v, 0);
    chk("R1 irq", {31'b0, warn_irq}, 0);
    chk("R1 rstreq", {31'b0, reset_req}, 0);

    // R2/R4 sweep: single key from idle
    for (int k = 0; k < 256; k++) begin
      do_reset();
      wr(6'h30, k);
      rd(6'h10, v); chk("R2 R4 idle key", v & 32'h3, (k == 8'hA5) ? 1 : 0);
    end
    // R2/R3/R4/R5 sweep: every key after attention
    for (int k = 0; k < 256; k++) begin
      do_reset();
      key2(k[7:0]);
      rd(6'h10, v); chk("R2 R3 armed key", v & 32'h3, (k == 8'hF1) ? 2 : 0);
      gwr(6'h00, 32'h1);
      rd(6'h00, v); chk("R4 R5 write after key", v, (k == 8'hFF) ? 0 : 1);
    end

    do_reset();
    // R3 write without grant ignored, grant used by write
    wr(6'h00, 32'h2);
    rd(6'h00, v); chk("R3 no grant", v, 0);
    key2(8'hF1);
    wr(6'h3C, 32'h0);  // unmapped: grant kept
    rd(6'h10, v); chk("R3 grant kept", v & 32'h2, 2);
    wr(6'h00, 32'h1);
    rd(6'h00, v); chk("R3 granted write", v, 1);
    rd(6'h10, v); chk("R3 grant used", v & 32'h2, 0);

    // R10 control aliases
    gwr(6'h04, 32'h2); rd(6'h00, v); chk("R10 set alias", v, 3);
    gwr(6'h08, 32'h2); rd(6'h00, v); chk("R10 clr alias", v, 1);

    // R9 status flag writes
    gwr(6'h14, 32'h4); rd(6'h10, v); chk("R9 set alias", v & 32'h4, 4);
    chk("R8 irq on", {31'b0, warn_irq}, 1);
    gwr(6'h18, 32'h4); rd(6'h10, v); chk("R9 clr alias", v & 32'h4, 0);
    chk("R8 irq off", {31'b0, warn_irq}, 0);
    gwr(6'h10, 32'h4); rd(6'h10, v); chk("R9 force", v & 32'h4, 4);
    gwr(6'h08, 32'h1); chk("R8 irq gated", {31'b0, warn_irq}, 0);
    gwr(6'h10, 32'h0); rd(6'h10, v); chk("R9 clear", v & 32'h4, 0);
    gwr(6'h00, 32'h1);

    // thresholds ewth=5 rth=10, then count
    gwr(6'h20, 32'h000A_0005);
    repeat (4) @(negedge clk);
    key2(8'hEE);
    reg_addr = 6'h10;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk); #0.5;
      chk("R7 rstreq", {31'b0, reset_req}, (i == 10) ? 1 : 0);
      chk("R7 rth flag", reg_rdata & 32'h8, (i >= 10) ? 8 : 0);
      chk("R8 ewi flag", reg_rdata & 32'h4, (i >= 5) ? 4 : 0);
      chk("R8 irq", {31'b0, warn_irq}, (i >= 5) ? 1 : 0);
    end
    // R6 stop and restart
    key2(8'hDD);
    key2(8'hCC);
    rd(6'h10, v); chk("R6 restart", v & 32'h8, 0);
    repeat (15) @(negedge clk);
    rd(6'h10, v); chk("R6 stopped", v & 32'h8, 0);
    gwr(6'h10, 32'h0);

    // R12 halt freezes with ctrl bit1
    gwr(6'h00, 32'h3);
    dbg_halt = 1'b1;
    key2(8'hEE);
    reg_addr = 6'h10;
    repeat (20) @(negedge clk);
    #0.5; chk("R12 frozen", reg_rdata & 32'h8, 0);
    dbg_halt = 1'b0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk); #0.5;
      chk("R12 resumed", reg_rdata & 32'h8, (i >= 10) ? 8 : 0);
    end
    // R12 halt ignored with ctrl bit1 clear
    key2(8'hDD);
    gwr(6'h00, 32'h1);
    key2(8'hCC);
    dbg_halt = 1'b1;
    key2(8'hEE);
    reg_addr = 6'h10;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk); #0.5;
      chk("R12 no freeze", reg_rdata & 32'h8, (i >= 10) ? 8 : 0);
    end
    dbg_halt = 1'b0;

    // R11 update delay and write while busy
    key2(8'hDD);
    key2(8'hCC);
    key2(8'hF1);
    wr(6'h20, 32'h0000_0005);
    rd(6'h10, v); chk("R11 busy c1", v & 32'h18, 32'h10);
    rd(6'h20, v); chk("R11 staged", v, 32'h0000_0005);
    wr(6'h30, 32'hA5);
    rd(6'h10, v); chk("R11 busy c2", v & 32'h18, 32'h10);
    wr(6'h30, 32'hF1);
    rd(6'h10, v); chk("R11 busy c3", v & 32'h18, 32'h10);
    wr(6'h20, 32'h1234_1234);
    rd(6'h10, v); chk("R11 applied", v & 32'h1A, 32'h08);
    rd(6'h20, v); chk("R11 busy write ignored", v, 32'h0000_0005);

    // R5 lock
    gwr(6'h20, 32'h000A_0005);
    repeat (4) @(negedge clk);
    key2(8'hEE);
    key2(8'hFF);
    key2(8'hF1);
    rd(6'h10, v); chk("R5 no grant", v & 32'h2, 0);
    wr(6'h00, 32'h0);
    rd(6'h00, v); chk("R5 write blocked", v, 1);
    repeat (10) @(negedge clk);
    rd(6'h10, v); chk("R5 running", v & 32'h8, 8);
    key2(8'hCC);
    rd(6'h10, v); chk("R5 restart honored", v & 32'h8, 0);
    key2(8'hDD);
    repeat (10) @(negedge clk);
    rd(6'h10, v); chk("R5 stop ignored", v & 32'h8, 8);
    do_reset();
    key2(8'hF1);
    rd(6'h10, v); chk("R5 reset unlocks", v & 32'h2, 2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule